// File: doc/BRIEF.md
# Host-Side Boot Download Sequencer

This block runs on the host side of a processor-to-processor boot link. When it is told to start, it loads an N-word image of 24-bit program words into a target. The target exposes a 16-bit memory port: a write with the latch line high loads an address register, and a write with the latch line low stores data and then advances that address. The sequencer reads the image through a simple ROM interface, with one word of combinational read per address. It turns each word into port writes and paces every access on the target's active-low acknowledge.

Word 0 of the image is the target's restart vector, and writing it starts the target. The sequencer therefore latches program address 1 first and streams words 1 to N-1 in ascending order, relying on the target's auto-increment. It then latches address 0 and writes word 0 last. Each 24-bit word goes out as two writes: the upper sixteen bits first, then the low byte with a zero upper byte. An optional acknowledge timeout stops a stalled download and reports a fault.

The controller has six states. IDLE waits for start. ACK_WAIT holds the next value on the bus until acknowledge is low. STROBE drives select together with either latch or write for a set width. RELEASE drops all strobes for one cycle and steps to the next access. DONE is entered after the restart word, and FAULT after a timeout. The transitions are: IDLE/DONE/FAULT to ACK_WAIT on start; ACK_WAIT to STROBE on acknowledge low; ACK_WAIT to FAULT on timeout; STROBE to RELEASE when the width is reached; RELEASE to ACK_WAIT while accesses remain; RELEASE to DONE after the last one.

Top module: `boot_dl_seq`

## Requirements
- R1: While reset is held and just after it is released, bus_sel, bus_latch, bus_wr, busy, done and error are all low.
- R2: A start pulse in IDLE, DONE or FAULT begins a new download from its first access, and busy stays high until it ends. A start pulse while busy has no effect on the access sequence.
- R3: The first access is a latch cycle carrying 16'h4001. Bit 14 set selects program memory, bits 13:0 hold address 1, and bit 15 is zero.
- R4: Image words 1 to N-1 follow in ascending order with no latch cycle between them.
- R5: Each word is sent as two data writes: bits 23:8 first, then {8'h00, bits 7:0}. rom_addr presents the word's index while both writes are made.
- R6: An access starts (bus_sel rises) only in the cycle after a clock edge at which ack_n was sampled low.
- R7: A latch access drives bus_latch high and bus_wr low, and a data write drives the reverse. bus_latch and bus_wr are never high together, and neither is high without bus_sel.
- R8: Every access holds bus_sel, its strobe and bus_data unchanged for exactly STROBE_CLKS cycles. It is followed by at least one cycle with all strobes low.
- R9: After word N-1, a latch cycle carrying 16'h4000 is made, and then word 0 is written as its two halves. That is 2N+2 accesses in all.
- R10: After the last access done goes high and busy low, no further access is made, and done holds until the next start.
- R11: If ack_n stays high for more than TIMEOUT_CLKS consecutive cycles while an access is pending, error goes high, busy drops and no further access is made. Exactly TIMEOUT_CLKS such cycles are tolerated. A later start clears error and restarts from the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a download (one-cycle pulse) |
| rom_addr | output | AW | Index of the image word being sent |
| rom_data | input | 24 | Image word at rom_addr, combinational read |
| ack_n | input | 1 | Target acknowledge, low when ready |
| bus_sel | output | 1 | Target select, high during an access |
| bus_latch | output | 1 | Address-latch strobe |
| bus_wr | output | 1 | Data write strobe |
| bus_data | output | 16 | Address or data value |
| busy | output | 1 | Download in progress |
| done | output | 1 | Download finished, target started |
| error | output | 1 | Acknowledge timeout stopped the download |

## Verification
The bench compares every access against an order computed from the image table. This catches a design that sends word 0 first, latches again between words, swaps halves or forgets to zero the upper byte of the low half. It holds acknowledge high for exactly the timeout length and for one cycle more. A counter that is off by one would then either fault a legal stall or let a longer one through. It also models a target that stays busy after each write, pulses start in the middle of a run, and idles after done. A design that strobes without waiting, restarts on a stray start or keeps writing after finishing would show up as a misplaced or extra access.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;

    localparam int unsigned BUS_W      = 16;
    localparam int unsigned WORD_W     = 24;
    localparam int unsigned PM_SEL_BIT = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_WAIT,
        ST_STROBE,
        ST_RELEASE,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

    typedef enum logic [1:0] {
        SEG_LATCH_FIRST,
        SEG_BODY,
        SEG_LATCH_ZERO,
        SEG_RESTART
    } seg_t;

endpackage

// File: rtl/boot_dl_cnt.sv
module boot_dl_cnt #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign hit = (cnt_q == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8 / R11: the counter saturates at its limit and never wraps
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= CW'(LIMIT)));

endmodule

// File: rtl/boot_dl_step.sv
module boot_dl_step
    import boot_dl_pkg::*;
#(
    parameter int unsigned N_WORDS = 68,
    localparam int unsigned AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [WORD_W-1:0] rom_data,
    output logic [AW-1:0]     rom_addr,
    output logic [BUS_W-1:0]  bus_word,
    output logic              is_latch,
    output logic              last
);
    localparam logic [AW-1:0]    LAST_IDX  = AW'(N_WORDS - 1);
    localparam logic [BUS_W-1:0] PM_FLAG   = BUS_W'(1) << PM_SEL_BIT;
    localparam logic [BUS_W-1:0] LATCH_ONE = PM_FLAG | BUS_W'(1);
    localparam logic [BUS_W-1:0] LATCH_NUL = PM_FLAG;

    seg_t          seg_q;
    logic [AW-1:0] idx_q;
    logic          half_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seg_q  <= SEG_LATCH_FIRST;
            idx_q  <= '0;
            half_q <= 1'b0;
        end else if (advance) begin
            unique case (seg_q)
                SEG_LATCH_FIRST: begin
                    half_q <= 1'b0;
                    if (N_WORDS > 1) begin
                        seg_q <= SEG_BODY;
                        idx_q <= AW'(1);
                    end else begin
                        seg_q <= SEG_LATCH_ZERO;
                    end
                end
                SEG_BODY: begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                    end else if (idx_q == LAST_IDX) begin
                        seg_q  <= SEG_LATCH_ZERO;
                        half_q <= 1'b0;
                    end else begin
                        idx_q  <= idx_q + 1'b1;
                        half_q <= 1'b0;
                    end
                end
                SEG_LATCH_ZERO: begin
                    seg_q  <= SEG_RESTART;
                    half_q <= 1'b0;
                end
                SEG_RESTART: begin
                    half_q <= 1'b1;
                end
                default: seg_q <= SEG_LATCH_FIRST;
            endcase
        end
    end

    always_comb begin
        rom_addr = (seg_q == SEG_RESTART) ? '0 : idx_q;
        is_latch = (seg_q == SEG_LATCH_FIRST) || (seg_q == SEG_LATCH_ZERO);
        last     = (seg_q == SEG_RESTART) && half_q;
        unique case (seg_q)
            SEG_LATCH_FIRST: bus_word = LATCH_ONE;
            SEG_LATCH_ZERO:  bus_word = LATCH_NUL;
            default:         bus_word = half_q ? {8'h00, rom_data[7:0]}
                                               : rom_data[WORD_W-1:8];
        endcase
    end

    // R4: the word index stays within the image
    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q <= LAST_IDX));

    // R4: inside the body the index only ever steps up by one
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == SEG_BODY && $past(seg_q) == SEG_BODY && idx_q != $past(idx_q))
        |-> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/boot_dl_seq.sv
module boot_dl_seq
    import boot_dl_pkg::*;
#(
    parameter int unsigned N_WORDS      = 68,
    parameter int unsigned STROBE_CLKS  = 2,
    parameter int unsigned TIMEOUT_CLKS = 1024,
    localparam int unsigned AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [AW-1:0]     rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    input  logic              ack_n,
    output logic              bus_sel,
    output logic              bus_latch,
    output logic              bus_wr,
    output logic [BUS_W-1:0]  bus_data,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam int unsigned STROBE_LIM = (STROBE_CLKS > 0) ? STROBE_CLKS - 1 : 0;

    seq_state_t       state_q, state_d;
    logic             idle_like;
    logic             step_restart, step_advance;
    logic [BUS_W-1:0] step_word;
    logic             step_is_latch, step_last;
    logic             strobe_hit, wait_hit;

    assign idle_like    = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                          (state_q == ST_FAULT);
    assign step_restart = idle_like && start;
    assign step_advance = (state_q == ST_RELEASE) && !step_last;

    boot_dl_step #(
        .N_WORDS (N_WORDS)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (step_restart),
        .advance  (step_advance),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .bus_word (step_word),
        .is_latch (step_is_latch),
        .last     (step_last)
    );

    boot_dl_cnt #(
        .LIMIT (STROBE_LIM)
    ) u_strobe_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_STROBE),
        .inc   (state_q == ST_STROBE),
        .hit   (strobe_hit)
    );

    generate
        if (TIMEOUT_CLKS > 0) begin : g_timeout
            boot_dl_cnt #(
                .LIMIT (TIMEOUT_CLKS)
            ) u_wait_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (!(state_q == ST_ACK_WAIT && ack_n)),
                .inc   (state_q == ST_ACK_WAIT && ack_n),
                .hit   (wait_hit)
            );
        end else begin : g_no_timeout
            assign wait_hit = 1'b0;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: if (start) state_d = ST_ACK_WAIT;
            ST_ACK_WAIT: begin
                if (!ack_n)        state_d = ST_STROBE;
                else if (wait_hit) state_d = ST_FAULT;
            end
            ST_STROBE:  if (strobe_hit) state_d = ST_RELEASE;
            ST_RELEASE: state_d = step_last ? ST_DONE : ST_ACK_WAIT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_sel   = (state_q == ST_STROBE);
        bus_latch = (state_q == ST_STROBE) && step_is_latch;
        bus_wr    = (state_q == ST_STROBE) && !step_is_latch;
        bus_data  = ((state_q == ST_ACK_WAIT) || (state_q == ST_STROBE)) ? step_word : '0;
        busy      = (state_q == ST_ACK_WAIT) || (state_q == ST_STROBE) ||
                    (state_q == ST_RELEASE);
        done      = (state_q == ST_DONE);
        error     = (state_q == ST_FAULT);
    end

    // R7: latch and write strobes are mutually exclusive
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_latch && bus_wr));

    // R7: no strobe outside a selected access
    a_r7_strobe_in_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_latch || bus_wr) |-> bus_sel);

    // R6: an access starts only after acknowledge was seen low
    a_r6_ack_before_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sel) |-> $past(!ack_n));

    // R8: data and strobe kind held for the whole access
    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && $past(bus_sel)) |-> ($stable(bus_data) && $stable(bus_latch)));

    // R10: done and busy never together, done holds without start
    a_r10_done_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R11: a faulted sequencer makes no access
    a_r11_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!bus_sel && !busy));

endmodule

// File: tb/boot_dl_seq_tb.sv
module boot_dl_seq_tb;
    localparam int NW   = 6;
    localparam int SC   = 3;
    localparam int TO   = 20;
    localparam int AW   = $clog2(NW);
    localparam int TOTAL = 2 * NW + 2;

    localparam logic [23:0] ROM_TBL [NW] = '{
        24'hA1B2C3, 24'h123456, 24'hFEDCBA, 24'h00FF00, 24'h5A5A5A, 24'h80017F
    };

    // run table: pre-start acknowledge hold, target busy after each write, fault expected
    localparam int NRUNS = 5;
    localparam int RUN_TBL [NRUNS][3] = '{
        '{0,      0, 0},
        '{0,      3, 0},
        '{TO,     1, 0},
        '{TO + 1, 0, 1},
        '{0,      5, 0}
    };

    logic          clk = 1'b0;
    logic          rst_n, start;
    logic [AW-1:0] rom_addr;
    logic [23:0]   rom_data;
    logic          ack_n;
    logic          bus_sel, bus_latch, bus_wr, busy, done, error;
    logic [15:0]   bus_data;

    logic hold_ack   = 1'b0;
    logic model_busy = 1'b0;
    int   busy_len   = 0;
    int   run_no     = 0;
    int   n_checks   = 0;
    int   n_fail     = 0;

    // monitor state
    int          wr_cnt  = 0;
    int          seen_run = 0;
    int          busy_left = 0;
    int          width   = 0;
    logic        prev_sel = 1'b0;
    logic [15:0] held_data = '0;
    logic        held_latch = 1'b0;

    always #5 clk = ~clk;

    assign ack_n    = hold_ack | model_busy;
    assign rom_data = (int'(rom_addr) < NW) ? ROM_TBL[rom_addr] : 24'h0;

    boot_dl_seq #(
        .N_WORDS      (NW),
        .STROBE_CLKS  (SC),
        .TIMEOUT_CLKS (TO)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ack_n     (ack_n),
        .bus_sel   (bus_sel),
        .bus_latch (bus_latch),
        .bus_wr    (bus_wr),
        .bus_data  (bus_data),
        .busy      (busy),
        .done      (done),
        .error     (error)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_data(input int k);
        int i, h;
        if (k == 0) return 16'h4001;
        if (k == 2 * NW - 1) return 16'h4000;
        if (k <= 2 * (NW - 1)) begin
            i = 1 + (k - 1) / 2;
            h = (k - 1) % 2;
        end else begin
            i = 0;
            h = k - 2 * NW;
        end
        return h ? {8'h00, ROM_TBL[i][7:0]} : ROM_TBL[i][23:8];
    endfunction

    function automatic logic exp_latch(input int k);
        return (k == 0) || (k == 2 * NW - 1);
    endfunction

    // bus monitor and target busy model
    always @(negedge clk) begin
        if (seen_run != run_no) begin
            seen_run = run_no;
            wr_cnt   = 0;
        end
        if (rst_n) begin
            check(!(bus_latch && bus_wr), "R7", "latch and write together", 1, 0);
            if (bus_sel && !prev_sel) begin
                check(ack_n == 1'b0, "R6", "access while ack high", int'(ack_n), 0);
                check(wr_cnt < TOTAL, "R10", "extra access count", wr_cnt, TOTAL - 1);
                check(bus_data == exp_data(wr_cnt), "R3 R4 R5 R9", "access data",
                      int'(bus_data), int'(exp_data(wr_cnt)));
                check(bus_latch == exp_latch(wr_cnt) && bus_wr == !exp_latch(wr_cnt),
                      "R7", "strobe kind", int'({bus_latch, bus_wr}),
                      int'({exp_latch(wr_cnt), !exp_latch(wr_cnt)}));
                held_data  = bus_data;
                held_latch = bus_latch;
                width      = 1;
            end else if (bus_sel) begin
                check(bus_data == held_data && bus_latch == held_latch, "R8",
                      "held during access", int'(bus_data), int'(held_data));
                width++;
            end else if (prev_sel) begin
                check(width == SC, "R8", "strobe width", width, SC);
                wr_cnt++;
                busy_left = busy_len;
            end
            model_busy = (busy_left > 0);
            if (busy_left > 0) busy_left--;
        end
        prev_sel = bus_sel;
    end

    task automatic wait_end(output int cycles);
        cycles = 0;
        while (!(done || error) && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic pulse_start(input int hold);
        run_no++;
        hold_ack = (hold > 0);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (hold) @(negedge clk);
        hold_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({bus_sel, bus_latch, bus_wr, busy, done, error} == 6'b0, "R1",
              "outputs in reset", int'({bus_sel, bus_latch, bus_wr, busy, done, error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({bus_sel, bus_latch, bus_wr, busy, done, error} == 6'b0, "R1",
              "outputs after reset", int'({bus_sel, bus_latch, bus_wr, busy, done, error}), 0);

        // table-driven runs
        for (int r = 0; r < NRUNS; r++) begin
            busy_len = RUN_TBL[r][1];
            pulse_start(RUN_TBL[r][0]);
            if (RUN_TBL[r][0] == 0)
                check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
            wait_end(cyc);
            repeat (30) @(negedge clk);
            if (RUN_TBL[r][2] != 0) begin
                check(error == 1'b1 && done == 1'b0, "R11", "fault flag",
                      int'({error, done}), 2);
                check(busy == 1'b0, "R11", "busy after fault", int'(busy), 0);
                check(wr_cnt == 0, "R11", "accesses before fault", wr_cnt, 0);
            end else begin
                check(done == 1'b1 && error == 1'b0, "R10 R11", "done flag",
                      int'({error, done}), 1);
                check(busy == 1'b0, "R10", "busy after done", int'(busy), 0);
                check(wr_cnt == TOTAL, "R9", "access count", wr_cnt, TOTAL);
            end
        end

        // R2: start while busy is ignored
        busy_len = 2;
        pulse_start(0);
        repeat (25) @(negedge clk);
        check(busy == 1'b1, "R2", "busy mid run", int'(busy), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(cyc);
        repeat (40) @(negedge clk);
        check(done == 1'b1 && wr_cnt == TOTAL, "R2", "accesses with stray start",
              wr_cnt, TOTAL);
        // R10: done holds, no further accesses
        check(done == 1'b1 && !bus_sel, "R10", "done held idle", int'(done), 1);

        // R11: mid-run stall beyond the limit
        busy_len = 0;
        pulse_start(0);
        while (wr_cnt < 4) @(negedge clk);
        hold_ack = 1'b1;
        repeat (TO + 15) @(negedge clk);
        check(error == 1'b1 && busy == 1'b0, "R11", "mid-run fault",
              int'({error, busy}), 2);
        check(wr_cnt < TOTAL, "R11", "stopped early", wr_cnt, 5);
        hold_ack = 1'b0;
        repeat (10) @(negedge clk);
        check(!bus_sel && error == 1'b1, "R11", "quiet after fault", int'(bus_sel), 0);

        // R11: restart after fault clears error and completes
        pulse_start(0);
        check(error == 1'b0, "R11", "error cleared by start", int'(error), 0);
        wait_end(cyc);
        repeat (5) @(negedge clk);
        check(done == 1'b1 && wr_cnt == TOTAL, "R11", "recovery run", wr_cnt, TOTAL);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule